// File: doc/BRIEF.md
# Chained DMA Event Tracker

This block keeps one chained-trigger flag for each of 64 DMA channels and decides which channel is offered next to the transfer engine. A flag is raised when a transfer engine reports completion with chaining requested for that channel, or when the controller's internal early-completion path flags that channel. A raised flag places its channel ahead of every ordinary event. The flag does not depend on the channel's event-enable bit. It falls when the transfer engine accepts a chained grant for that channel.

When a chain arrives for a channel whose flag is already raised, the block does not queue a second request. It records the chain in a 64-bit missed-chain register and leaves the flag raised. Missed bits clear only through a dedicated write-one-to-clear input. A read port returns either half of the flag vector or either half of the missed vector, one cycle after an address strobe. The flags have no write path.

Top module: `chain_evt_tracker`

## Requirements
- R1: After reset, gnt_valid_o is 0, rd_data_o is 0, and every chained flag and every missed bit is 0.
- R2: A completion with cc_valid_i=1 and cc_chain_i=1 raises the flag of channel cc_chan_i. With cc_chain_i=0 it raises no flag.
- R3: ec_valid_i=1 raises the flag of channel ec_chan_i. A completion and an early completion in the same cycle both take effect.
- R4: When no grant is outstanding and any flag is raised, the next grant is the lowest-numbered flagged channel, with gnt_chained_o=1. This holds whatever evt_en_i and evt_pend_i carry.
- R5: When no flag is raised, the next grant is the lowest channel that has both evt_pend_i and evt_en_i at 1, with gnt_chained_o=0. A pending event whose enable is 0 is never granted.
- R6: A grant holds gnt_valid_o, gnt_chan_o and gnt_chained_o steady until gnt_accept_i. The cycle after acceptance, gnt_valid_o is 0, and a new grant can appear the cycle after that.
- R7: Accepting a chained grant lowers that channel's flag. If a new chain for the same channel arrives in the accept cycle, the flag stays raised and no missed bit is recorded.
- R8: A chain that arrives for a channel whose flag is already raised (and not being accepted in that cycle) sets that channel's missed bit, and the flag stays raised.
- R9: Missed bits clear only where miss_clr_i has a 1. A missed event arriving in the same cycle as the clear takes precedence, so the bit ends set.
- R10: A cycle with rd_strobe_i=1 loads rd_data_o on the next edge. rd_addr_i 0 selects flags 31..0, 1 selects flags 63..32, 2 selects missed bits 31..0, and 3 selects missed bits 63..32, with channel n at bit n mod 32. rd_data_o holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cc_valid_i | input | 1 | Completion code valid |
| cc_chan_i | input | 6 | Channel of the completion code |
| cc_chain_i | input | 1 | Completion requests chaining |
| ec_valid_i | input | 1 | Early completion valid |
| ec_chan_i | input | 6 | Channel of the early completion |
| evt_pend_i | input | 64 | Ordinary pending events, one per channel |
| evt_en_i | input | 64 | Event enables, one per channel |
| gnt_valid_o | output | 1 | Grant offered to the transfer engine |
| gnt_chan_o | output | 6 | Granted channel |
| gnt_chained_o | output | 1 | Grant came from a chained flag |
| gnt_accept_i | input | 1 | Transfer engine takes the grant |
| miss_clr_i | input | 64 | Write-one-to-clear for missed bits |
| rd_strobe_i | input | 1 | Read address strobe |
| rd_addr_i | input | 2 | Read word select |
| rd_data_o | output | 32 | Read data, registered |

## Verification
Two functions can land on the same channel in the same cycle: acceptance of a chained grant and the arrival of a fresh chain. The bench provokes this by driving gnt_accept_i together with a chain completion for the granted channel. It then reads the flag word and the missed word, expecting the flag still raised, no missed bit, and the same channel granted again. A second collision, a missed event together with its own clear bit, is driven and judged by reading back the missed word with the bit set.

// File: rtl/chain_evt_pkg.sv
package chain_evt_pkg;
  localparam int unsigned DEF_NUM_CH = 64;
  localparam int unsigned DEF_WORD_W = 32;

  typedef enum logic [0:0] {
    SRC_ORD   = 1'b0,
    SRC_CHAIN = 1'b1
  } gnt_src_e;
endpackage

// File: rtl/chain_evt_pick.sv
// Lowest-index set-bit finder.
module chain_evt_pick #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign found_o = |vec_i;
endmodule

// File: rtl/chain_evt_bits.sv
// Chained flags and missed-chain log.
module chain_evt_bits #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cc_valid_i,
  input  logic [CH_W-1:0]   cc_chan_i,
  input  logic              cc_chain_i,
  input  logic              ec_valid_i,
  input  logic [CH_W-1:0]   ec_chan_i,
  input  logic              clr_valid_i,
  input  logic [CH_W-1:0]   clr_chan_i,
  input  logic [NUM_CH-1:0] miss_clr_i,
  output logic [NUM_CH-1:0] chained_o,
  output logic [NUM_CH-1:0] missed_o
);
  logic [NUM_CH-1:0] chained_q, missed_q;
  logic [NUM_CH-1:0] set_vec, clr_vec, miss_set;

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if (cc_valid_i && cc_chain_i) set_vec[cc_chan_i] = 1'b1;
    if (ec_valid_i)               set_vec[ec_chan_i] = 1'b1;
    if (clr_valid_i)              clr_vec[clr_chan_i] = 1'b1;
  end

  // A chain colliding with acceptance re-arms the flag and is not a miss.
  assign miss_set = set_vec & chained_q & ~clr_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chained_q <= '0;
      missed_q  <= '0;
    end else begin
      chained_q <= (chained_q & ~clr_vec) | set_vec;
      missed_q  <= (missed_q & ~miss_clr_i) | miss_set;
    end
  end

  assign chained_o = chained_q;
  assign missed_o  = missed_q;

  AST_MISS_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_valid_i && cc_chain_i && chained_q[cc_chan_i] &&
     !(clr_valid_i && clr_chan_i == cc_chan_i))
    |=> (missed_q[$past(cc_chan_i)] && chained_q[$past(cc_chan_i)])); // R8

  AST_CHAIN_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_valid_i && !(cc_valid_i && cc_chain_i && cc_chan_i == clr_chan_i) &&
     !(ec_valid_i && ec_chan_i == clr_chan_i))
    |=> !chained_q[$past(clr_chan_i)]); // R7
endmodule

// File: rtl/chain_evt_rdport.sv
// Registered word read of {missed, chained}.
module chain_evt_rdport #(
  parameter int unsigned NUM_CH    = 64,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 2 * NUM_CH / WORD_W,
  parameter int unsigned ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   chained_i,
  input  logic [NUM_CH-1:0]   missed_i,
  input  logic                rd_strobe_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [WORD_W-1:0]   rd_data_o
);
  logic [2*NUM_CH-1:0] all_bits;
  logic [WORD_W-1:0]   rd_sel, rd_q;

  assign all_bits = {missed_i, chained_i};

  always_comb begin
    rd_sel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_addr_i == ADDR_W'(w)) rd_sel = all_bits[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          rd_q <= '0;
    else if (rd_strobe_i) rd_q <= rd_sel;
  end

  assign rd_data_o = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_strobe_i |=> $stable(rd_data_o)); // R10
endmodule

// File: rtl/chain_evt_tracker.sv
module chain_evt_tracker
  import chain_evt_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned WORD_W = DEF_WORD_W,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned RD_A_W = $clog2(2 * NUM_CH / WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cc_valid_i,
  input  logic [CH_W-1:0]   cc_chan_i,
  input  logic              cc_chain_i,
  input  logic              ec_valid_i,
  input  logic [CH_W-1:0]   ec_chan_i,
  input  logic [NUM_CH-1:0] evt_pend_i,
  input  logic [NUM_CH-1:0] evt_en_i,
  output logic              gnt_valid_o,
  output logic [CH_W-1:0]   gnt_chan_o,
  output logic              gnt_chained_o,
  input  logic              gnt_accept_i,
  input  logic [NUM_CH-1:0] miss_clr_i,
  input  logic              rd_strobe_i,
  input  logic [RD_A_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [NUM_CH-1:0] chained, missed;
  logic [NUM_CH-1:0] ord_vec;
  logic              ch_found, ord_found;
  logic [CH_W-1:0]   ch_idx, ord_idx;
  logic              gnt_valid_q;
  logic [CH_W-1:0]   gnt_chan_q;
  gnt_src_e          gnt_src_q;
  logic              clr_valid;

  assign ord_vec   = evt_pend_i & evt_en_i;
  assign clr_valid = gnt_valid_q && gnt_accept_i && (gnt_src_q == SRC_CHAIN);

  chain_evt_bits #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bits (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cc_valid_i  (cc_valid_i),
    .cc_chan_i   (cc_chan_i),
    .cc_chain_i  (cc_chain_i),
    .ec_valid_i  (ec_valid_i),
    .ec_chan_i   (ec_chan_i),
    .clr_valid_i (clr_valid),
    .clr_chan_i  (gnt_chan_q),
    .miss_clr_i  (miss_clr_i),
    .chained_o   (chained),
    .missed_o    (missed)
  );

  chain_evt_pick #(.N(NUM_CH), .IDX_W(CH_W)) u_pick_chain (
    .vec_i   (chained),
    .found_o (ch_found),
    .idx_o   (ch_idx)
  );

  chain_evt_pick #(.N(NUM_CH), .IDX_W(CH_W)) u_pick_ord (
    .vec_i   (ord_vec),
    .found_o (ord_found),
    .idx_o   (ord_idx)
  );

  // Grant reloads only from idle: one bubble after each accept.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_valid_q <= 1'b0;
      gnt_chan_q  <= '0;
      gnt_src_q   <= SRC_ORD;
    end else if (gnt_valid_q) begin
      if (gnt_accept_i) gnt_valid_q <= 1'b0;
    end else if (ch_found) begin
      gnt_valid_q <= 1'b1;
      gnt_chan_q  <= ch_idx;
      gnt_src_q   <= SRC_CHAIN;
    end else if (ord_found) begin
      gnt_valid_q <= 1'b1;
      gnt_chan_q  <= ord_idx;
      gnt_src_q   <= SRC_ORD;
    end
  end

  assign gnt_valid_o   = gnt_valid_q;
  assign gnt_chan_o    = gnt_chan_q;
  assign gnt_chained_o = (gnt_src_q == SRC_CHAIN);

  chain_evt_rdport #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chained_i   (chained),
    .missed_i    (missed),
    .rd_strobe_i (rd_strobe_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o)
  );

  AST_GNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && !gnt_accept_i)
    |=> (gnt_valid_o && $stable(gnt_chan_o) && $stable(gnt_chained_o))); // R6

  AST_CHAIN_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && ch_found) |=> (gnt_valid_o && gnt_chained_o)); // R4

  AST_ORD_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gnt_valid_o && !ch_found && ord_found)
    |=> (gnt_valid_o && !gnt_chained_o && $past(evt_en_i[ord_idx]))); // R5

  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_valid_o && gnt_accept_i) |=> !gnt_valid_o); // R6
endmodule

// File: tb/chain_evt_tracker_tb_top.sv
`timescale 1ns/1ps
module chain_evt_tracker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cc_valid_i = 1'b0;
  logic [5:0]  cc_chan_i = '0;
  logic        cc_chain_i = 1'b0;
  logic        ec_valid_i = 1'b0;
  logic [5:0]  ec_chan_i = '0;
  logic [63:0] evt_pend_i = '0;
  logic [63:0] evt_en_i = '0;
  logic        gnt_valid_o;
  logic [5:0]  gnt_chan_o;
  logic        gnt_chained_o;
  logic        gnt_accept_i = 1'b0;
  logic [63:0] miss_clr_i = '0;
  logic        rd_strobe_i = 1'b0;
  logic [1:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;

  int vec_cnt = 0;
  int bad_cnt = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  chain_evt_tracker dut_i (.*);

  // {cc_v, cc_ch, cc_chain, ec_v, ec_ch, rd_word, expected}
  localparam int NV = 8;
  localparam logic [48:0] VECS [NV] = '{
    {1'b1, 6'd5,  1'b1, 1'b0, 6'd0,  2'd0, 32'h0000_0020},  // R2
    {1'b1, 6'd40, 1'b0, 1'b0, 6'd0,  2'd1, 32'h0000_0000},  // R2 no chain flag
    {1'b0, 6'd0,  1'b0, 1'b1, 6'd40, 2'd1, 32'h0000_0100},  // R3
    {1'b1, 6'd5,  1'b1, 1'b0, 6'd0,  2'd2, 32'h0000_0020},  // R8
    {1'b0, 6'd0,  1'b0, 1'b0, 6'd0,  2'd0, 32'h0000_0020},  // R8 flag kept
    {1'b0, 6'd0,  1'b0, 1'b1, 6'd63, 2'd1, 32'h8000_0100},  // R3
    {1'b1, 6'd40, 1'b1, 1'b0, 6'd0,  2'd3, 32'h0000_0100},  // R8
    {1'b1, 6'd0,  1'b1, 1'b1, 6'd31, 2'd0, 32'h8000_0021}   // R2 R3 together
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_strobe_i = 1'b1;
    rd_addr_i   = a;
    @(negedge clk_i);
    rd_strobe_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic check_gnt(input string tag, input logic [5:0] ch, input logic chd);
    check({tag, " valid"},   {31'd0, gnt_valid_o},   32'd1);
    check({tag, " chan"},    {26'd0, gnt_chan_o},    {26'd0, ch});
    check({tag, " chained"}, {31'd0, gnt_chained_o}, {31'd0, chd});
  endtask

  // Check current grant, accept it, check the bubble, wait for reload.
  task automatic take(input string tag, input logic [5:0] ch, input logic chd);
    check_gnt(tag, ch, chd);
    gnt_accept_i = 1'b1;
    @(negedge clk_i);
    gnt_accept_i = 1'b0;
    check({tag, " R6 idle after accept"}, {31'd0, gnt_valid_o}, 32'd0);
    @(negedge clk_i);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    check("R1 gnt_valid", {31'd0, gnt_valid_o}, 32'd0);
    check("R1 rd_data", rd_data_o, 32'd0);
    for (int w = 0; w < 4; w++) begin
      rd_word(2'(w), d);
      check("R1 word", d, 32'd0);
    end

    // Vector table; no accept, so flags only grow.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      cc_valid_i = VECS[i][48];
      cc_chan_i  = VECS[i][47:42];
      cc_chain_i = VECS[i][41];
      ec_valid_i = VECS[i][40];
      ec_chan_i  = VECS[i][39:34];
      @(negedge clk_i);
      cc_valid_i = 1'b0;
      ec_valid_i = 1'b0;
      rd_word(VECS[i][33:32], d);
      check($sformatf("R2/R3/R8 vector %0d", i), d, VECS[i][31:0]);
    end

    // Flags {0,5,31,40,63}, missed {5,40}. First grant ch5 held (R6).
    evt_pend_i = 64'h6;
    evt_en_i   = 64'h2;
    @(negedge clk_i);
    take("R6 held ch5", 6'd5, 1'b1);
    rd_word(2'd0, d);
    check("R7 flag5 cleared", d, 32'h8000_0001);
    take("R4 lowest ch0", 6'd0, 1'b1);
    // R4: chained ch31 beats enabled ordinary ch1
    check_gnt("R4 chain over ordinary", 6'd31, 1'b1);

    // R7 collision: accept ch31 with a new chain for ch31
    gnt_accept_i = 1'b1;
    cc_valid_i = 1'b1; cc_chan_i = 6'd31; cc_chain_i = 1'b1;
    @(negedge clk_i);
    gnt_accept_i = 1'b0;
    cc_valid_i = 1'b0;
    check("R6 idle", {31'd0, gnt_valid_o}, 32'd0);
    @(negedge clk_i);
    check_gnt("R7 regrant ch31", 6'd31, 1'b1);
    rd_word(2'd2, d);
    check("R7 no miss on collision", d, 32'h0000_0020);
    rd_word(2'd0, d);
    check("R7 flag31 kept", d, 32'h8000_0000);

    take("R4 ch31", 6'd31, 1'b1);
    take("R4 ch40", 6'd40, 1'b1);
    take("R4 ch63", 6'd63, 1'b1);

    // R5 ordinary grant; drop pend with accept
    check_gnt("R5 ordinary ch1", 6'd1, 1'b0);
    gnt_accept_i = 1'b1;
    evt_pend_i = 64'h4;
    @(negedge clk_i);
    gnt_accept_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R5 disabled not granted", {31'd0, gnt_valid_o}, 32'd0);
    evt_pend_i = '0;

    // R9 clear
    miss_clr_i = 64'h20;
    @(negedge clk_i);
    miss_clr_i = '0;
    rd_word(2'd2, d);
    check("R9 bit5 cleared", d, 32'd0);
    rd_word(2'd3, d);
    check("R9 bit40 untouched", d, 32'h0000_0100);

    // R9 set wins over same-cycle clear
    ec_valid_i = 1'b1; ec_chan_i = 6'd33;
    @(negedge clk_i);
    ec_valid_i = 1'b0;
    cc_valid_i = 1'b1; cc_chan_i = 6'd33; cc_chain_i = 1'b1;
    miss_clr_i = 64'h2_0000_0000;
    @(negedge clk_i);
    cc_valid_i = 1'b0;
    miss_clr_i = '0;
    rd_word(2'd3, d);
    check("R9 set wins", d, 32'h0000_0102);

    // R10 hold between strobes
    cc_valid_i = 1'b1; cc_chan_i = 6'd34; cc_chain_i = 1'b1;
    @(negedge clk_i);
    cc_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R10 rd_data held", rd_data_o, 32'h0000_0102);
    rd_word(2'd1, d);
    check("R10 high flag word", d, 32'h0000_0006);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      vec_cnt++;
      bad_cnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
    end
  end
endmodule